// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block connects four level-sensitive PCI interrupt lines to a bank of sixteen legacy ISA interrupt request outputs. Each PCI line has a byte-wide steering register that names its target ISA line. Software writes and reads these four registers through a small byte-wide register port, with a 2-bit address and a write strobe.

A PCI line drives an ISA output only while its steering register holds a number below sixteen. Any larger value turns the line off, and that includes the value loaded at reset. When several PCI lines point at the same ISA line, their levels are OR-merged onto it. Every ISA output follows the PCI levels and the stored routes combinationally. A shared output therefore drops in the same cycle as the last contributing PCI line. A rewritten route moves the interrupt in the cycle that follows the write edge.

Top module: `pirq_steer_router`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four steering registers load 0x80. After that edge every register reads back 0x80 and every ISA output is low, whatever the PCI levels.
- R2: A write (`reg_wr_en` high at a rising edge) stores `reg_wdata` in the register selected by `reg_addr`. PCI line n uses address n. The other three registers keep their values. `reg_rdata` always shows the stored byte of the addressed register, combinationally.
- R3: When the register of PCI line n holds a value v below 16 (0x00 to 0x0F), ISA output v carries the level of PCI line n.
- R4: When the register of a PCI line holds 16 or more (for example 0x10, 0x80 or 0xFF), that line affects no ISA output.
- R5: Each ISA output is the logical OR of the levels of all PCI lines whose registers hold that output's number.
- R6: An ISA output falls in the same cycle as the last PCI line routed to it deasserts. No interrupt level is held or latched.
- R7: ISA outputs that no PCI line targets are driven low.
- R8: After a register is rewritten, the route takes effect from the cycle following the write edge. If the line is asserted, the old target drops and the new target rises together.
- R9: A reset that arrives mid-operation returns all registers to 0x80 and releases every ISA output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Selects the steering register, which is also the PCI line index |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 8 | Byte to write |
| reg_rdata | output | 8 | Stored byte of the addressed register |
| pci_irq | input | 4 | PCI interrupt levels, bit n is line n |
| isa_irq | output | 16 | ISA interrupt request levels, bit k is ISA line k |

## Verification
The first stimulus steers each line to a distinct target, which separates correct index decoding from wiring that ignores the register value. A second set places the register value on either side of the validity edge (0x0F, 0x10, 0x80, 0xFF). These cases separate a full-byte range check from one that looks only at the low four bits. Shared-target patterns raise and drop the merged lines one at a time. They show whether an output is a true OR or follows only one of its sources. A random sweep then mixes writes, PCI toggles and mid-run resets against the reference model, which exposes retargeting hazards and stale routes.

// File: rtl/pirq_route_pkg.sv
package pirq_route_pkg;
  parameter int unsigned PR_NUM_PCI  = 4;
  parameter int unsigned PR_NUM_ISA  = 16;
  parameter int unsigned PR_BYTE_W   = 8;
  parameter logic [7:0]  PR_RST_ROUTE = 8'h80;

  typedef logic [PR_BYTE_W-1:0] route_byte_t;
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned BYTE_W    = 8,
  parameter logic [BYTE_W-1:0] RST_VAL = 8'h80,
  localparam int unsigned ADDR_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [BYTE_W-1:0]                 wdata,
  output logic [BYTE_W-1:0]                 rdata,
  output logic [NUM_LINES-1:0][BYTE_W-1:0]  route_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LINES; i++) route_q[i] <= RST_VAL;
    end else if (wr_en && (32'(addr) < NUM_LINES)) begin
      route_q[addr] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (32'(addr) < NUM_LINES) rdata = route_q[addr];
  end

endmodule

// File: rtl/pirq_route_decode.sv
module pirq_route_decode #(
  parameter int unsigned NUM_ISA = 16,
  parameter int unsigned BYTE_W  = 8,
  localparam int unsigned SEL_W  = (NUM_ISA > 1) ? $clog2(NUM_ISA) : 1,
  localparam logic [BYTE_W:0] LIMIT = (BYTE_W+1)'(NUM_ISA)
) (
  input  logic [BYTE_W-1:0]  route,
  output logic [NUM_ISA-1:0] target
);

  logic in_range;
  assign in_range = ({1'b0, route} < LIMIT);

  always_comb begin
    target = '0;
    if (in_range) target[route[SEL_W-1:0]] = 1'b1;
  end

endmodule

// File: rtl/pirq_route_merge.sv
module pirq_route_merge #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned NUM_ISA   = 16
) (
  input  logic [NUM_LINES-1:0]              lvl,
  input  logic [NUM_LINES-1:0][NUM_ISA-1:0] target,
  output logic [NUM_ISA-1:0]                merged
);

  for (genvar k = 0; k < NUM_ISA; k++) begin : g_out
    logic [NUM_LINES-1:0] column;
    always_comb begin
      for (int n = 0; n < NUM_LINES; n++) column[n] = target[n][k] & lvl[n];
    end
    assign merged[k] = |column;
  end

endmodule

// File: rtl/pirq_steer_router.sv
module pirq_steer_router
  import pirq_route_pkg::*;
#(
  parameter int unsigned NUM_PCI = PR_NUM_PCI,
  parameter int unsigned NUM_ISA = PR_NUM_ISA,
  parameter int unsigned BYTE_W  = PR_BYTE_W,
  parameter logic [BYTE_W-1:0] RST_ROUTE = PR_RST_ROUTE,
  localparam int unsigned ADDR_W = (NUM_PCI > 1) ? $clog2(NUM_PCI) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr_en,
  input  logic [BYTE_W-1:0]  reg_wdata,
  output logic [BYTE_W-1:0]  reg_rdata,
  input  logic [NUM_PCI-1:0] pci_irq,
  output logic [NUM_ISA-1:0] isa_irq
);

  logic [NUM_PCI-1:0][BYTE_W-1:0]  route_q;
  logic [NUM_PCI-1:0][NUM_ISA-1:0] target;

  pirq_route_regs #(
    .NUM_LINES(NUM_PCI), .BYTE_W(BYTE_W), .RST_VAL(RST_ROUTE)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .route_q(route_q)
  );

  for (genvar n = 0; n < NUM_PCI; n++) begin : g_line
    pirq_route_decode #(.NUM_ISA(NUM_ISA), .BYTE_W(BYTE_W)) dec_i (
      .route(route_q[n]), .target(target[n])
    );
  end

  pirq_route_merge #(.NUM_LINES(NUM_PCI), .NUM_ISA(NUM_ISA)) merge_i (
    .lvl(pci_irq), .target(target), .merged(isa_irq)
  );

endmodule

// File: rtl/pirq_steer_router_chk.sv
module pirq_steer_router_chk #(
  parameter int unsigned NUM_PCI = 4,
  parameter int unsigned NUM_ISA = 16,
  parameter int unsigned BYTE_W  = 8,
  parameter logic [BYTE_W-1:0] RST_ROUTE = 8'h80,
  localparam int unsigned ADDR_W = (NUM_PCI > 1) ? $clog2(NUM_PCI) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_wr_en,
  input logic [BYTE_W-1:0]  reg_wdata,
  input logic [BYTE_W-1:0]  reg_rdata,
  input logic [NUM_PCI-1:0] pci_irq,
  input logic [NUM_ISA-1:0] isa_irq
);

  logic [NUM_PCI-1:0][BYTE_W-1:0] shadow_q;
  logic [NUM_ISA-1:0] expect_isa;
  logic [NUM_PCI-1:0] routed_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PCI; i++) shadow_q[i] <= RST_ROUTE;
    end else if (reg_wr_en && (32'(reg_addr) < NUM_PCI)) begin
      shadow_q[reg_addr] <= reg_wdata;
    end
  end

  always_comb begin
    expect_isa = '0;
    routed_lvl = '0;
    for (int i = 0; i < NUM_PCI; i++) begin
      if (32'(shadow_q[i]) < NUM_ISA) begin
        routed_lvl[i] = pci_irq[i];
        if (pci_irq[i]) expect_isa[32'(shadow_q[i])] = 1'b1;
      end
    end
  end

  // R1 / R9: the cycle after reset, the addressed register reads the reset byte
  assert_reset_route_R1: assert property (@(posedge clk)
    rst |=> (reg_rdata == RST_ROUTE));

  // R2: readback follows the writes seen at the port
  assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (reg_rdata == shadow_q[reg_addr]));

  // R5: outputs equal the OR of the routed lines
  assert_or_merge_R5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (isa_irq == expect_isa));

  // R4: no more outputs active than lines holding a valid route
  assert_invalid_silent_R4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ($countones(isa_irq) <= $countones(routed_lvl)));

  // R6: with every PCI line low, every ISA line is low
  assert_all_low_R6: assert property (@(posedge clk) disable iff (rst)
    (pci_irq == '0) |-> (isa_irq == '0));

endmodule

bind pirq_steer_router pirq_steer_router_chk #(
  .NUM_PCI(NUM_PCI), .NUM_ISA(NUM_ISA), .BYTE_W(BYTE_W), .RST_ROUTE(RST_ROUTE)
) chk_i (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pci_irq(pci_irq),
  .isa_irq(isa_irq)
);

// File: tb/pirq_steer_router_tb_top.sv
module pirq_steer_router_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [3:0]  pci_irq = '0;
  logic [15:0] isa_irq;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit done    = 0;
  int model_reg [4];

  always #2 clk = ~clk;

  pirq_steer_router dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pci_irq(pci_irq),
    .isa_irq(isa_irq)
  );

  function automatic logic [15:0] model_isa();
    logic [15:0] v = '0;
    for (int i = 0; i < 4; i++)
      if (model_reg[i] < 16 && pci_irq[i]) v[model_reg[i]] = 1'b1;
    return v;
  endfunction

  task automatic check(input string tag);
    logic [15:0] e;
    e = model_isa();
    vectors++;
    if (isa_irq !== e) begin
      fails++;
      $display("FAIL %s isa_irq actual=%h expected=%h", tag, isa_irq, e);
    end
    vectors++;
    if (reg_rdata !== 8'(model_reg[reg_addr])) begin
      fails++;
      $display("FAIL %s reg_rdata[%0d] actual=%h expected=%h", tag, reg_addr,
               reg_rdata, 8'(model_reg[reg_addr]));
    end
  endtask

  // one cycle: drive at negedge, check before the edge, update model after
  task automatic step(input bit r, input bit we, input logic [1:0] a,
                      input logic [7:0] d, input logic [3:0] p, input string tag);
    @(negedge clk);
    rst = r; reg_wr_en = we; reg_addr = a; reg_wdata = d; pci_irq = p;
    #1;
    if (!done_reset_first) check(tag);
    @(posedge clk);
    if (r) for (int i = 0; i < 4; i++) model_reg[i] = 8'h80;
    else if (we) model_reg[a] = d;
    done_reset_first = 0;
  endtask

  bit done_reset_first = 1;

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [3:0] p,
                    input string tag);
    step(0, 1, a, d, p, tag);
  endtask

  task automatic idle(input logic [1:0] a, input logic [3:0] p, input string tag);
    step(0, 0, a, 8'h00, p, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model_reg[i] = 8'h80;
    step(1, 0, 0, 0, 4'hF, "R1");
    step(1, 0, 0, 0, 4'hF, "R1");
    // R1: all registers 0x80, all outputs low with all PCI lines high
    for (int a = 0; a < 4; a++) idle(2'(a), 4'hF, "R1");
    // R3: distinct targets per line
    wr(0, 8'h03, 4'h0, "R2");
    wr(1, 8'h07, 4'h0, "R2");
    wr(2, 8'h00, 4'h0, "R2");
    wr(3, 8'h0F, 4'h0, "R2");
    for (int p = 0; p < 16; p++) idle(2'(p % 4), 4'(p), "R3");
    // R2: readback of each register
    for (int a = 0; a < 4; a++) idle(2'(a), 4'h0, "R2");
    // R4: boundary and reset-value routes
    wr(0, 8'h10, 4'hF, "R4");
    idle(0, 4'hF, "R4");
    wr(1, 8'h80, 4'hF, "R4");
    wr(2, 8'hFF, 4'hF, "R4");
    idle(2, 4'hF, "R4");
    idle(3, 4'hF, "R3");   // 0x0F is still valid
    idle(3, 4'h7, "R7");
    // R5 / R6: three lines shared on ISA 5
    wr(0, 8'h05, 4'h0, "R5");
    wr(1, 8'h05, 4'h0, "R5");
    wr(2, 8'h05, 4'h0, "R5");
    idle(0, 4'h1, "R5");
    idle(0, 4'h3, "R5");
    idle(0, 4'h7, "R5");
    idle(1, 4'h6, "R6");
    idle(1, 4'h4, "R6");
    idle(1, 4'h0, "R6");
    idle(2, 4'h2, "R5");
    // R8: retarget while asserted
    wr(1, 8'h09, 4'h2, "R8");
    idle(1, 4'h2, "R8");
    wr(1, 8'h20, 4'h2, "R8");
    idle(1, 4'h2, "R8");
    wr(1, 8'h0C, 4'h2, "R8");
    idle(1, 4'h2, "R8");
    // R9: reset in mid-operation
    step(1, 0, 1, 0, 4'hF, "R9");
    for (int a = 0; a < 4; a++) idle(2'(a), 4'hF, "R9");
    // random sweep compared on every clock
    for (int n = 0; n < 3000; n++) begin
      int unsigned rv = $urandom;
      logic [7:0] d = (rv[3:0] < 4) ? 8'($urandom) : {4'h0, 4'($urandom)};
      bit r = (rv[13:8] == 0);
      step(r, rv[4], 2'($urandom), d, 4'($urandom), "R5");
    end
    finish_run();
  end

endmodule